// File: doc/BRIEF.md
# Software Watchdog with Forced Reset

The block watches for a stalled program. Once it is armed, software must restart its timeout window before a fixed number of clock cycles have passed. If it does not, the block issues a one-cycle system reset pulse. After the pulse it returns to its disarmed state, and it keeps a sticky cause flag so that boot code can tell that the last reset came from the watchdog.

Software can also trigger a reset on purpose by writing the cause flag while the watchdog is armed. A cause flag that is never read back works like a trap: if the watchdog is armed again while the flag is still set, a reset follows at once.

Two strap inputs change the behaviour:

- One strap keeps the watchdog running no matter what the software enable says.
- Another strap turns a halt request into an immediate reset. When this strap is low, a halt freezes the counter. A wake-up interrupt then resumes counting after a settling delay of 256 or 512 cycles.

The control word is 3 bits wide and has this layout:

- bit 0: arm
- bit 1: restart
- bit 2: cause flag

Top module: `wdg_guard`

## Requirements
- R1: When the watchdog is armed by a write with bit 0 = 1, and there is no later restart, `sys_rst` is high in the cycle that follows the TIMEOUT-th rising edge after the arming edge. TIMEOUT defaults to 16000.
- R2: A write with bits 1 and 0 both set restarts the window, so the next reset comes TIMEOUT edges after that write. `reg_rdata` bit 1 reads 1 for the single cycle after the write, and hardware then returns it to 0.
- R3: Every reset event drives `sys_rst` high for exactly one cycle. Afterwards `reg_rdata` bit 0 reads 0.
- R4: After a reset event, `reg_rdata` bit 2 reads 1. A cycle with `reg_rd` high clears it at the next edge. After `rst_n` the flag is 0.
- R5: A write with bit 2 = 1 while the watchdog is already armed (bit 0 set, or `always_on` high) gives a reset pulse in the cycle after that write edge. When the watchdog is not armed, the same write is ignored, and the flag and the arm bit stay 0.
- R6: If the cause flag is 1 when the effective enable (`always_on` OR arm bit) goes from 0 to 1, a reset follows at the first edge after the enable rises.
- R7: While `always_on` is high, the counter runs whatever the arm bit holds. Writes that clear bit 0 do not stop it, and a reset pulse recurs every TIMEOUT edges.
- R8: With `halt_resets` low, a `halt_req` sampled while the watchdog is armed freezes the counter. No reset is issued until `wake_irq` arrives.
- R9: Counting resumes only after a delay following the wake edge: WAKE_SHORT (256) edges when `long_wake` is 0, or WAKE_LONG (512) edges when it is 1. The counter then continues from the value it had when frozen.
- R10: With `halt_resets` high, a `halt_req` sampled while the watchdog is armed gives a reset pulse in the next cycle. A `halt_req` sampled while the watchdog is disarmed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low; clears all state including the cause flag |
| reg_wr | input | 1 | Control write strobe |
| reg_wdata | input | 3 | Write data: bit0 arm, bit1 restart, bit2 cause flag |
| reg_rd | input | 1 | Status read strobe; clears the cause flag |
| reg_rdata | output | 3 | Status: bit0 arm, bit1 restart pending, bit2 cause flag |
| halt_req | input | 1 | Halt request |
| wake_irq | input | 1 | Wake-up interrupt ending a halt |
| always_on | input | 1 | Strap: watchdog permanently armed |
| halt_resets | input | 1 | Strap: halt while armed causes a reset |
| long_wake | input | 1 | Strap: selects the 512-cycle wake delay instead of 256 |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
The properties assume three things about the inputs:

- `reg_wr` and `reg_rd` are single-cycle strobes.
- The straps `always_on`, `halt_resets` and `long_wake` change only while no halt is pending.
- `wake_irq` is only meaningful after a halt.

The stimulus respects these assumptions. It pulses each strobe for exactly one cycle and changes the straps only between scenarios. It toggles `always_on` only to exercise R6 and R7, and it reads the flag back only through the normal read strobe.

// File: rtl/wdg_guard.sv
module wdg_guard #(
  parameter int TIMEOUT    = 16000,
  parameter int WAKE_SHORT = 256,
  parameter int WAKE_LONG  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_wdata,
  input  logic       reg_rd,
  output logic [2:0] reg_rdata,
  input  logic       halt_req,
  input  logic       wake_irq,
  input  logic       always_on,
  input  logic       halt_resets,
  input  logic       long_wake,
  output logic       sys_rst
);
  localparam int CW = $clog2(TIMEOUT);
  localparam int WW = $clog2(WAKE_LONG + 1);

  logic          arm, kick, flag, en_q, halted;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wake_cnt;

  wire en_eff    = always_on | arm;
  wire wr_kick   = reg_wr & reg_wdata[1];
  wire force_req = reg_wr & reg_wdata[2] & en_eff;
  wire stale     = en_eff & ~en_q & flag;
  wire halt_hit  = halt_req & en_eff & ~halted;
  wire halt_trip = halt_hit & halt_resets;
  wire running   = en_eff & ~halted & (wake_cnt == '0) & ~halt_hit;
  wire expire    = running & (cnt == CW'(TIMEOUT - 1));
  wire trip      = force_req | stale | halt_trip | expire;

  assign reg_rdata = {flag, kick, arm};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst  <= 1'b0;
      kick     <= 1'b0;
      flag     <= 1'b0;
      arm      <= 1'b0;
      en_q     <= 1'b0;
      halted   <= 1'b0;
      cnt      <= '0;
      wake_cnt <= '0;
    end else begin
      sys_rst <= trip;
      kick    <= wr_kick & ~trip;
      if (trip) begin
        flag     <= 1'b1;
        arm      <= 1'b0;
        en_q     <= always_on;
        halted   <= 1'b0;
        cnt      <= '0;
        wake_cnt <= '0;
      end else begin
        en_q <= en_eff;
        if (reg_rd) flag <= 1'b0;
        if (reg_wr) arm <= reg_wdata[0];

        if (!en_eff) begin
          halted   <= 1'b0;
          wake_cnt <= '0;
        end else if (halt_hit) begin
          halted <= 1'b1;
        end else if (halted && wake_irq) begin
          halted   <= 1'b0;
          wake_cnt <= long_wake ? WW'(WAKE_LONG) : WW'(WAKE_SHORT);
        end else if (wake_cnt != '0) begin
          wake_cnt <= wake_cnt - 1'b1;
        end

        if (wr_kick || !en_eff) cnt <= '0;
        else if (running)       cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_wdata,
  input logic       reg_rd,
  input logic [2:0] reg_rdata,
  input logic       always_on,
  input logic       halt_resets,
  input logic       halted,
  input logic       sys_rst
);
  p_pulse_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  p_arm_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> !reg_rdata[0]);

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> reg_rdata[2]);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (!reg_rdata[2] || sys_rst));

  p_kick_self_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !reg_wr) |=> !reg_rdata[1]);

  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[2] && (always_on || reg_rdata[0])) |=> sys_rst);

  p_stale_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(always_on || reg_rdata[0]) && reg_rdata[2] && !sys_rst) |=> sys_rst);

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !reg_wr && !halt_resets) |=> !sys_rst);
endmodule

bind wdg_guard wdg_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .always_on(always_on),
  .halt_resets(halt_resets), .halted(halted), .sys_rst(sys_rst)
);

// File: tb/wdg_guard_tb_top.sv
`timescale 1ns/1ps
module wdg_guard_tb_top;
  localparam int T = 16000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_wdata = '0;
  logic [2:0] reg_rdata;
  logic       halt_req = 1'b0, wake_irq = 1'b0;
  logic       always_on = 1'b0, halt_resets = 1'b0, long_wake = 1'b0;
  logic       sys_rst;

  int cyc = 0, checks = 0, fails = 0;
  int exp_q[$];
  logic prev_rst = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_guard dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .halt_req(halt_req),
    .wake_irq(wake_irq), .always_on(always_on), .halt_resets(halt_resets),
    .long_wake(long_wake), .sys_rst(sys_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every reset pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (sys_rst) begin
        chk(!prev_rst, "R3 pulse width", 2, 1);
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected reset", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R1 reset cycle", cyc, e);
        end
      end
      prev_rst <= sys_rst;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] d, output int e);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    e = cyc;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_halt(output int e);
    halt_req = 1'b1;
    @(negedge clk);
    e = cyc;
    halt_req = 1'b0;
  endtask

  task automatic pulse_wake(output int e);
    wake_irq = 1'b1;
    @(negedge clk);
    e = cyc;
    wake_irq = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] exp, input string req);
    reg_rd = 1'b1;
    #1 chk(reg_rdata == exp, req, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
    #1 chk(reg_rdata[2] == 1'b0, "R4 flag cleared by read", reg_rdata[2], 0);
  endtask

  task automatic halt_run(input bit lng, input int n);
    int e0, eh, ew, h;
    long_wake = lng;
    wr(3'b001, e0);
    tick(98);
    pulse_halt(eh);
    h = eh - e0;
    tick(17000);
    pulse_wake(ew);
    exp_q.push_back(ew + n + T - h + 1);
    wait_until(ew + n + T - h + 3);
    rd_chk(3'b100, lng ? "R9 long wake delay" : "R8 halt freeze");
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int e, e2, c;
    tick(4);
    rst_n = 1'b1;
    #1 chk(reg_rdata == 3'b000, "R4 reset state", reg_rdata, 0);
    chk(sys_rst == 1'b0, "R3 reset output low", sys_rst, 0);
    tick(2);

    // R1 plain timeout
    wr(3'b001, e);
    exp_q.push_back(e + T);
    wait_until(e + T + 2);
    rd_chk(3'b100, "R3 R4 status after timeout");

    // R2 restart
    wr(3'b001, e);
    tick(10000);
    wr(3'b011, e2);
    #1 chk(reg_rdata[1] == 1'b1, "R2 restart bit set", reg_rdata[1], 1);
    exp_q.push_back(e2 + T);
    @(negedge clk);
    #1 chk(reg_rdata[1] == 1'b0, "R2 restart bit cleared", reg_rdata[1], 0);
    wait_until(e2 + T + 2);
    rd_chk(3'b100, "R2 status after restart window");

    // R5 force ignored when disarmed, then honoured when armed
    wr(3'b100, e);
    tick(5);
    rd_chk(3'b000, "R5 force ignored while disarmed");
    wr(3'b001, e);
    wr(3'b101, e2);
    exp_q.push_back(e2);
    tick(3);
    #1 chk(reg_rdata == 3'b100, "R5 forced reset status", reg_rdata, 4);

    // R6 stale flag, software arming
    wr(3'b001, e);
    exp_q.push_back(e + 1);
    tick(3);
    #1 chk(reg_rdata == 3'b100, "R6 stale flag disarms", reg_rdata, 4);

    // R6 stale flag via always_on, then R7 periodic
    c = cyc;
    always_on = 1'b1;
    exp_q.push_back(c + 1);
    exp_q.push_back(c + 1 + T);
    tick(50);
    wr(3'b000, e);
    wait_until(c + 1 + T);
    always_on = 1'b0;
    tick(2);
    chk(exp_q.size() == 0, "R7 always-on pulses seen", exp_q.size(), 0);
    rd_chk(3'b100, "R7 status after always-on");

    // R8 / R9 halt then wake
    halt_resets = 1'b0;
    halt_run(1'b0, 256);
    halt_run(1'b1, 512);
    long_wake = 1'b0;

    // R10 reset on halt
    halt_resets = 1'b1;
    pulse_halt(e);
    tick(3);
    #1 chk(reg_rdata == 3'b000, "R10 halt while disarmed ignored", reg_rdata, 0);
    wr(3'b001, e);
    tick(5);
    pulse_halt(e2);
    exp_q.push_back(e2);
    tick(3);
    rd_chk(3'b100, "R10 halt reset status");
    halt_resets = 1'b0;

    tick(10);
    chk(exp_q.size() == 0, "R1 all expected resets seen", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule